// File: doc/BRIEF.md
# Double-Buffered Flash Channel Front End

This block sits on one flash channel, between a shared host register/data port and the page operation sequencer. It holds a small set of command registers and two page-sized dual-port buffers. The host can fill or drain one buffer while the flash side uses the other. Commands move buffer ownership between host and flash. Each command is handed to the sequencer in posting order. A level-held interrupt is raised when a page transfer on the flash bus completes.

A read takes three steps. The host posts the command. The sequencer fills the buffer and the block interrupts. The host then copies the page out and releases the buffer. A write takes more steps. The host claims a buffer, fills it and posts the write, and the sequencer copies the page to the die. The interrupt fires as soon as that copy ends. The host then posts a confirm, which starts programming. The next write transfer is held back until the program busy phase reports done.

Top module: `fcm_channel`

## Requirements
- R1: After reset, the status register (index 4) reads 0, `irq_o` is 0 and `seq_valid_o` is 0. Both buffers are free.
- R2: Host data-port writes land only in a buffer in the host-owned state. A write to a buffer in any other state leaves its contents unchanged.
- R3: A command word written to register 3 uses bits [2:0] as the opcode and bit 4 as the buffer select. The opcodes are: 0 claim, 1 read, 2 write, 3 confirm, 4 release. A read on a free buffer, or a write on a host-owned buffer, puts the buffer in the flash-owned state (2). It then raises `seq_valid_o` with `seq_op_o` 0 for a read or 1 for a write. The request carries the buffer and the address and die registers (indices 0, 1, 2) as they were when posted. The request holds stable until `seq_ready_i`.
- R4: When `xfer_done_i` ends a read transfer, the buffer becomes full (state 3) and `irq_o` rises. The words the flash port wrote are readable on the host data port.
- R5: When `xfer_done_i` ends a write transfer, the buffer becomes free and `irq_o` rises. During that transfer, the flash port reads the data the host wrote.
- R6: A confirm after a completed write transfer issues `seq_op_o` 2 carrying the current address registers. No write transfer is issued while that program is outstanding, that is, until `prog_done_i`. `prog_done_i` does not raise `irq_o`.
- R7: Only one transfer is on the flash bus at a time. Queued buffers are issued in posting order. The host may drain one buffer while the other is being filled.
- R8: A command whose buffer is in the wrong state, a confirm without a completed write, or an unknown opcode sets the sticky error bit (status bit 1). The buffer state is left unchanged.
- R9: Status layout: bit 0 interrupt, bit 1 error, [3:2] buffer 0 state, [5:4] buffer 1 state, bit 6 transfer active, bit 7 program busy. States are encoded 0 free, 1 host, 2 flash, 3 full. Writing register 4 with bit 0 set clears the interrupt, and with bit 1 set clears the error. If a new set lands in the same cycle as a clear, the set wins.
- R10: Release moves a full or host-owned buffer to free. Claim moves a free buffer to host-owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| buf_we_i | input | 1 | Host data-port write |
| buf_sel_i | input | 1 | Host data-port buffer select |
| buf_adr_i | input | AW | Host data-port word index |
| buf_wdata_i | input | DW | Host data-port write data |
| buf_rdata_o | output | DW | Host data-port read data, one cycle latency |
| irq_o | output | 1 | Level interrupt |
| seq_valid_o | output | 1 | Sequencer request valid |
| seq_ready_i | input | 1 | Sequencer accepts request |
| seq_op_o | output | 2 | 0 read, 1 write, 2 program |
| seq_buf_o | output | 1 | Buffer of the request |
| seq_addr_lo_o | output | 32 | Address word 0 |
| seq_addr_hi_o | output | 32 | Address word 1 |
| seq_die_o | output | 32 | Target die |
| fl_we_i | input | 1 | Flash-side buffer write (read transfers) |
| fl_adr_i | input | AW | Flash-side word index |
| fl_wdata_i | input | DW | Flash-side write data |
| fl_rdata_o | output | DW | Flash-side read data, one cycle latency |
| xfer_done_i | input | 1 | Transfer of the active job finished |
| prog_done_i | input | 1 | Program busy phase finished |

## Verification
Two events can fall in the same cycle: the end of a transfer, which sets the interrupt, and a host status write that clears it. The bench drives `xfer_done_i` and a clear write to register 4 on the same clock edge. It expects `irq_o` to read 1 afterwards, because the set wins. A second case checks ordering. A write is posted while a program is busy, and the bench expects no write request until after `prog_done_i`. A second read is posted while the first is on the bus, and it must not be issued until the first transfer is done.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int NBUF  = 2;
  localparam int REG_W = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] REG_ADDR_LO = 3'd0;
  localparam logic [REG_AW-1:0] REG_ADDR_HI = 3'd1;
  localparam logic [REG_AW-1:0] REG_DIE     = 3'd2;
  localparam logic [REG_AW-1:0] REG_CMD     = 3'd3;
  localparam logic [REG_AW-1:0] REG_STAT    = 3'd4;

  localparam logic [1:0] BUF_FREE  = 2'd0;
  localparam logic [1:0] BUF_HOST  = 2'd1;
  localparam logic [1:0] BUF_FLASH = 2'd2;
  localparam logic [1:0] BUF_FULL  = 2'd3;

  localparam logic [2:0] OP_CLAIM   = 3'd0;
  localparam logic [2:0] OP_READ    = 3'd1;
  localparam logic [2:0] OP_WRITE   = 3'd2;
  localparam logic [2:0] OP_CONFIRM = 3'd3;
  localparam logic [2:0] OP_RELEASE = 3'd4;

  localparam logic [1:0] SEQ_RD   = 2'd0;
  localparam logic [1:0] SEQ_WR   = 2'd1;
  localparam logic [1:0] SEQ_PROG = 2'd2;

  typedef struct packed {
    logic [REG_W-1:0] lo;
    logic [REG_W-1:0] hi;
    logic [REG_W-1:0] die;
  } job_t;
endpackage

// File: rtl/fcm_page_buf.sv
module fcm_page_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 528,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_adr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_adr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  // owners never write the same buffer in the same cycle
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem[a_adr_i] <= a_wdata_i;
    if (b_we_i) mem[b_adr_i] <= b_wdata_i;
    a_rdata_o <= mem[a_adr_i];
    b_rdata_o <= mem[b_adr_i];
  end
endmodule

// File: rtl/fcm_regs.sv
module fcm_regs import fcm_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [REG_W-1:0]  status_i,
  output job_t              job_o,
  output logic              cmd_fire_o,
  output logic              clr_irq_o,
  output logic              clr_err_o,
  output logic [REG_W-1:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      job_o <= '0;
    end else if (we_i) begin
      if (addr_i == REG_ADDR_LO) job_o.lo  <= wdata_i;
      if (addr_i == REG_ADDR_HI) job_o.hi  <= wdata_i;
      if (addr_i == REG_DIE)     job_o.die <= wdata_i;
    end
  end

  assign cmd_fire_o = we_i && (addr_i == REG_CMD);
  assign clr_irq_o  = we_i && (addr_i == REG_STAT) && wdata_i[0];
  assign clr_err_o  = we_i && (addr_i == REG_STAT) && wdata_i[1];

  always_comb begin
    case (addr_i)
      REG_ADDR_LO: rdata_o = job_o.lo;
      REG_ADDR_HI: rdata_o = job_o.hi;
      REG_DIE:     rdata_o = job_o.die;
      REG_STAT:    rdata_o = status_i;
      default:     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fcm_sched.sv
module fcm_sched import fcm_pkg::*; (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_fire_i,
  input  logic [2:0]           cmd_op_i,
  input  logic                 cmd_buf_i,
  input  job_t                 job_i,
  input  logic                 clr_irq_i,
  input  logic                 clr_err_i,
  input  logic                 seq_ready_i,
  input  logic                 xfer_done_i,
  input  logic                 prog_done_i,
  output logic [NBUF-1:0][1:0] st_o,
  output logic                 irq_o,
  output logic                 err_o,
  output logic                 active_o,
  output logic                 act_buf_o,
  output logic                 act_wr_o,
  output logic                 prog_busy_o,
  output logic                 seq_valid_o,
  output logic [1:0]           seq_op_o,
  output logic                 seq_buf_o,
  output job_t                 seq_job_o
);
  logic [NBUF-1:0] qd_q, wr_q;
  logic head_q, wpend_q, conf_q;
  job_t job_q [NBUF];
  job_t conf_job_q;
  logic [1:0] cmd_st;
  logic cmd_ok, can_launch, wr_ok, launch_job, launch_prog, done_ev;

  assign cmd_st      = st_o[cmd_buf_i];
  assign can_launch  = !seq_valid_o && !active_o;
  assign wr_ok       = !prog_busy_o && !wpend_q && !conf_q;
  assign launch_prog = can_launch && conf_q;
  assign launch_job  = can_launch && !conf_q && qd_q[head_q] && (!wr_q[head_q] || wr_ok);
  assign done_ev     = xfer_done_i && active_o;

  always_comb begin
    case (cmd_op_i)
      OP_CLAIM:   cmd_ok = (cmd_st == BUF_FREE);
      OP_READ:    cmd_ok = (cmd_st == BUF_FREE);
      OP_WRITE:   cmd_ok = (cmd_st == BUF_HOST);
      OP_CONFIRM: cmd_ok = wpend_q && !conf_q;
      OP_RELEASE: cmd_ok = (cmd_st == BUF_FULL) || (cmd_st == BUF_HOST);
      default:    cmd_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o        <= '0;
      qd_q        <= '0;
      wr_q        <= '0;
      head_q      <= 1'b0;
      wpend_q     <= 1'b0;
      conf_q      <= 1'b0;
      irq_o       <= 1'b0;
      err_o       <= 1'b0;
      active_o    <= 1'b0;
      act_buf_o   <= 1'b0;
      act_wr_o    <= 1'b0;
      prog_busy_o <= 1'b0;
      seq_valid_o <= 1'b0;
      seq_op_o    <= SEQ_RD;
      seq_buf_o   <= 1'b0;
    end else begin
      if (seq_valid_o && seq_ready_i) seq_valid_o <= 1'b0;
      if (prog_done_i) prog_busy_o <= 1'b0;

      if (launch_prog) begin
        seq_valid_o <= 1'b1;
        seq_op_o    <= SEQ_PROG;
        conf_q      <= 1'b0;
        prog_busy_o <= 1'b1;
      end else if (launch_job) begin
        seq_valid_o      <= 1'b1;
        seq_op_o         <= wr_q[head_q] ? SEQ_WR : SEQ_RD;
        seq_buf_o        <= head_q;
        qd_q[head_q]     <= 1'b0;
        active_o         <= 1'b1;
        act_buf_o        <= head_q;
        act_wr_o         <= wr_q[head_q];
        head_q           <= ~head_q;
      end

      if (cmd_fire_i && cmd_ok) begin
        case (cmd_op_i)
          OP_CLAIM:   st_o[cmd_buf_i] <= BUF_HOST;
          OP_READ, OP_WRITE: begin
            st_o[cmd_buf_i] <= BUF_FLASH;
            qd_q[cmd_buf_i] <= 1'b1;
            wr_q[cmd_buf_i] <= (cmd_op_i == OP_WRITE);
            if (!qd_q[~cmd_buf_i]) head_q <= cmd_buf_i;
          end
          OP_CONFIRM: begin
            conf_q  <= 1'b1;
            wpend_q <= 1'b0;
          end
          default:    st_o[cmd_buf_i] <= BUF_FREE;
        endcase
      end

      if (done_ev) begin
        active_o <= 1'b0;
        st_o[act_buf_o] <= act_wr_o ? BUF_FREE : BUF_FULL;
        if (act_wr_o) wpend_q <= 1'b1;
      end

      if (clr_irq_i) irq_o <= 1'b0;
      if (done_ev)   irq_o <= 1'b1;
      if (clr_err_i) err_o <= 1'b0;
      if (cmd_fire_i && !cmd_ok) err_o <= 1'b1;
    end
  end

  // payload registers, no reset needed
  always_ff @(posedge clk_i) begin
    if (cmd_fire_i && cmd_ok && (cmd_op_i == OP_READ || cmd_op_i == OP_WRITE))
      job_q[cmd_buf_i] <= job_i;
    if (cmd_fire_i && cmd_ok && cmd_op_i == OP_CONFIRM) conf_job_q <= job_i;
    if (launch_prog)     seq_job_o <= conf_job_q;
    else if (launch_job) seq_job_o <= job_q[head_q];
  end
endmodule

// File: rtl/fcm_channel.sv
module fcm_channel import fcm_pkg::*; #(
  parameter int DW         = 32,
  parameter int PAGE_WORDS = 528,
  localparam int AW        = $clog2(PAGE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              buf_we_i,
  input  logic              buf_sel_i,
  input  logic [AW-1:0]     buf_adr_i,
  input  logic [DW-1:0]     buf_wdata_i,
  output logic [DW-1:0]     buf_rdata_o,
  output logic              irq_o,
  output logic              seq_valid_o,
  input  logic              seq_ready_i,
  output logic [1:0]        seq_op_o,
  output logic              seq_buf_o,
  output logic [REG_W-1:0]  seq_addr_lo_o,
  output logic [REG_W-1:0]  seq_addr_hi_o,
  output logic [REG_W-1:0]  seq_die_o,
  input  logic              fl_we_i,
  input  logic [AW-1:0]     fl_adr_i,
  input  logic [DW-1:0]     fl_wdata_i,
  output logic [DW-1:0]     fl_rdata_o,
  input  logic              xfer_done_i,
  input  logic              prog_done_i
);
  job_t reg_job, seq_job;
  logic cmd_fire, clr_irq, clr_err;
  logic [NBUF-1:0][1:0] bst;
  logic sch_err, sch_active, act_buf, act_wr, prog_busy, sel_q;
  logic [REG_W-1:0] status;
  logic [DW-1:0] h_rd [NBUF];
  logic [DW-1:0] f_rd [NBUF];

  assign status = {{(REG_W-8){1'b0}}, prog_busy, sch_active, bst[1], bst[0], sch_err, irq_o};

  fcm_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(status), .job_o(reg_job), .cmd_fire_o(cmd_fire),
    .clr_irq_o(clr_irq), .clr_err_o(clr_err), .rdata_o(reg_rdata_o)
  );

  fcm_sched u_sched (
    .clk_i, .rst_ni,
    .cmd_fire_i(cmd_fire), .cmd_op_i(reg_wdata_i[2:0]), .cmd_buf_i(reg_wdata_i[4]),
    .job_i(reg_job), .clr_irq_i(clr_irq), .clr_err_i(clr_err),
    .seq_ready_i, .xfer_done_i, .prog_done_i,
    .st_o(bst), .irq_o, .err_o(sch_err), .active_o(sch_active),
    .act_buf_o(act_buf), .act_wr_o(act_wr), .prog_busy_o(prog_busy),
    .seq_valid_o, .seq_op_o, .seq_buf_o, .seq_job_o(seq_job)
  );

  assign seq_addr_lo_o = seq_job.lo;
  assign seq_addr_hi_o = seq_job.hi;
  assign seq_die_o     = seq_job.die;

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    fcm_page_buf #(.DW(DW), .DEPTH(PAGE_WORDS)) u_buf (
      .clk_i,
      .a_we_i(buf_we_i && (buf_sel_i == 1'(g)) && (bst[g] == BUF_HOST)),
      .a_adr_i(buf_adr_i), .a_wdata_i(buf_wdata_i), .a_rdata_o(h_rd[g]),
      .b_we_i(fl_we_i && sch_active && !act_wr && (act_buf == 1'(g))),
      .b_adr_i(fl_adr_i), .b_wdata_i(fl_wdata_i), .b_rdata_o(f_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= buf_sel_i;
  end

  assign buf_rdata_o = h_rd[sel_q];
  assign fl_rdata_o  = f_rd[act_buf];
endmodule

// File: rtl/fcm_channel_chk.sv
module fcm_channel_chk import fcm_pkg::*; (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_o,
  input logic                 reg_we_i,
  input logic [REG_AW-1:0]    reg_addr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic                 seq_valid_o,
  input logic                 seq_ready_i,
  input logic [1:0]           seq_op_o,
  input logic                 seq_buf_o,
  input logic                 xfer_done_i,
  input logic                 prog_done_i,
  input logic                 active_i,
  input logic                 err_i,
  input logic [NBUF-1:0][1:0] bst_i
);
  logic prog_out_q, stat_wr, cmd_wr;

  assign stat_wr = reg_we_i && (reg_addr_i == REG_STAT);
  assign cmd_wr  = reg_we_i && (reg_addr_i == REG_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prog_out_q <= 1'b0;
    else if (seq_valid_o && seq_ready_i && seq_op_o == SEQ_PROG) prog_out_q <= 1'b1;
    else if (prog_done_i) prog_out_q <= 1'b0;
  end

  assert_irq_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(stat_wr && reg_wdata_i[0])) |=> irq_o);

  assert_err_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(stat_wr && reg_wdata_i[1])) |=> err_i);

  assert_bad_read_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && reg_wdata_i[2:0] == OP_READ && bst_i[reg_wdata_i[4]] != BUF_FREE) |=> err_i);

  assert_seq_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_valid_o && !seq_ready_i) |=> (seq_valid_o && $stable(seq_op_o) && $stable(seq_buf_o)));

  assert_done_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && active_i) |=> irq_o);

  assert_no_wr_in_prog_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_valid_o && seq_op_o == SEQ_WR) |-> !prog_out_q);
endmodule

bind fcm_channel fcm_channel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .seq_valid_o(seq_valid_o), .seq_ready_i(seq_ready_i), .seq_op_o(seq_op_o),
  .seq_buf_o(seq_buf_o), .xfer_done_i(xfer_done_i), .prog_done_i(prog_done_i),
  .active_i(sch_active), .err_i(sch_err), .bst_i(bst)
);

// File: tb/fcm_channel_tb_top.sv
`timescale 1ns/1ps
module fcm_channel_tb_top;
  localparam int DW = 32;
  localparam int PW = 528;
  localparam int AW = $clog2(PW);

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd4;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic buf_we = 1'b0, buf_sel = 1'b0;
  logic [AW-1:0] buf_adr = '0;
  logic [DW-1:0] buf_wdata = '0, buf_rdata;
  logic irq, seq_valid, seq_buf;
  logic seq_ready = 1'b0;
  logic [1:0] seq_op;
  logic [31:0] seq_lo, seq_hi, seq_die;
  logic fl_we = 1'b0;
  logic [AW-1:0] fl_adr = '0;
  logic [DW-1:0] fl_wdata = '0, fl_rdata;
  logic xfer_done = 1'b0, prog_done = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fcm_channel #(.DW(DW), .PAGE_WORDS(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .buf_we_i(buf_we), .buf_sel_i(buf_sel), .buf_adr_i(buf_adr), .buf_wdata_i(buf_wdata),
    .buf_rdata_o(buf_rdata), .irq_o(irq),
    .seq_valid_o(seq_valid), .seq_ready_i(seq_ready), .seq_op_o(seq_op), .seq_buf_o(seq_buf),
    .seq_addr_lo_o(seq_lo), .seq_addr_hi_o(seq_hi), .seq_die_o(seq_die),
    .fl_we_i(fl_we), .fl_adr_i(fl_adr), .fl_wdata_i(fl_wdata), .fl_rdata_o(fl_rdata),
    .xfer_done_i(xfer_done), .prog_done_i(prog_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic status(output logic [31:0] v);
    reg_addr = 3'd4; #0.5; v = reg_rdata;
  endtask

  task automatic bwr(input logic s, input int a, input logic [31:0] d);
    @(negedge clk); buf_we = 1'b1; buf_sel = s; buf_adr = AW'(a); buf_wdata = d;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic brd(input logic s, input int a, output logic [31:0] d);
    @(negedge clk); buf_sel = s; buf_adr = AW'(a);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic fwr(input int a, input logic [31:0] d);
    @(negedge clk); fl_we = 1'b1; fl_adr = AW'(a); fl_wdata = d;
    @(negedge clk); fl_we = 1'b0;
  endtask

  task automatic frd(input int a, output logic [31:0] d);
    @(negedge clk); fl_adr = AW'(a);
    @(negedge clk); d = fl_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic pulse_prog();
    @(negedge clk); prog_done = 1'b1;
    @(negedge clk); prog_done = 1'b0;
  endtask

  task automatic wait_seq(input string tag);
    for (int i = 0; i < 20; i++) begin
      if (seq_valid) break;
      @(negedge clk);
    end
    chk(tag, {31'd0, seq_valid}, 32'd1);
  endtask

  task automatic ack();
    @(negedge clk); seq_ready = 1'b1;
    @(negedge clk); seq_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    status(s);
    chk("R1 status", s, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 seq_valid", {31'd0, seq_valid}, 32'd0);
  endtask

  task automatic t_claim_ignore();
    logic [31:0] s, d;
    reg_wr(3, 32'h00);                  // claim buf0
    status(s); chk("R10 claim", s, 32'h4);
    bwr(0, 3, 32'hAAAA_0003);
    reg_wr(3, 32'h04);                  // release buf0
    status(s); chk("R10 release", s, 32'h0);
    bwr(0, 3, 32'h5555_0003);           // buffer free: ignored
    brd(0, 3, d); chk("R2 write ignored", d, 32'hAAAA_0003);
  endtask

  task automatic t_read();
    logic [31:0] s, d;
    reg_wr(0, 32'h111); reg_wr(1, 32'h222); reg_wr(2, 32'h3);
    reg_wr(3, 32'h11);                  // read buf1
    wait_seq("R3 read issued");
    chk("R3 op", {30'd0, seq_op}, 32'd0);
    chk("R3 buf", {31'd0, seq_buf}, 32'd1);
    chk("R3 addr", seq_lo, 32'h111);
    chk("R3 die", seq_die, 32'h3);
    repeat (3) @(negedge clk);
    chk("R3 hold", {31'd0, seq_valid}, 32'd1);
    ack();
    for (int i = 0; i < 4; i++) fwr(i, 32'hC0 + i);
    pulse_done();
    status(s); chk("R4 full+irq", s, 32'h31);
    brd(1, 2, d); chk("R4 data", d, 32'hC2);
    reg_wr(4, 32'h1);
    status(s); chk("R9 irq clear", s, 32'h30);
    reg_wr(3, 32'h14);
  endtask

  task automatic t_illegal();
    logic [31:0] s;
    reg_wr(3, 32'h02);                  // write on free buffer
    status(s); chk("R8 bad write", s, 32'h2);
    reg_wr(4, 32'h2);
    status(s); chk("R9 err clear", s, 32'h0);
    reg_wr(3, 32'h03);                  // confirm with nothing pending
    status(s); chk("R8 bad confirm", s, 32'h2);
    reg_wr(4, 32'h2);
    reg_wr(3, 32'h07);
    status(s); chk("R8 bad opcode", s, 32'h2);
    reg_wr(4, 32'h2);
  endtask

  task automatic t_write();
    logic [31:0] s, d;
    reg_wr(3, 32'h00);
    for (int i = 0; i < 4; i++) bwr(0, i, 32'hD0 + i);
    reg_wr(0, 32'h555);
    reg_wr(3, 32'h02);
    wait_seq("R3 write issued");
    chk("R3 write op", {30'd0, seq_op}, 32'd1);
    chk("R3 write addr", seq_lo, 32'h555);
    ack();
    frd(1, d); chk("R5 flash read", d, 32'hD1);
    pulse_done();
    status(s); chk("R5 free+irq", s, 32'h41 & 32'h01);
    reg_wr(4, 32'h1);
    reg_wr(0, 32'h777);
    reg_wr(3, 32'h03);
    wait_seq("R6 confirm issued");
    chk("R6 prog op", {30'd0, seq_op}, 32'd2);
    chk("R6 prog addr", seq_lo, 32'h777);
    ack();
    reg_wr(3, 32'h10);
    bwr(1, 0, 32'hF0);
    reg_wr(3, 32'h12);
    repeat (5) @(negedge clk);
    chk("R6 write blocked", {31'd0, seq_valid}, 32'd0);
    pulse_prog();
    chk("R6 no irq on prog", {31'd0, irq}, 32'd0);
    wait_seq("R6 write after prog");
    chk("R6 write buf", {31'd0, seq_buf}, 32'd1);
    ack();
    frd(0, d); chk("R5 flash read buf1", d, 32'hF0);
    pulse_done();
    reg_wr(4, 32'h1);
    reg_wr(3, 32'h03);
    wait_seq("R6 confirm 2");
    ack();
    pulse_prog();
    status(s); chk("R6 idle", s, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] s, d;
    reg_wr(3, 32'h11);
    reg_wr(3, 32'h01);
    wait_seq("R7 first");
    chk("R7 first buf", {31'd0, seq_buf}, 32'd1);
    ack();
    repeat (3) @(negedge clk);
    chk("R7 one at a time", {31'd0, seq_valid}, 32'd0);
    fwr(0, 32'hE1);
    pulse_done();
    wait_seq("R7 second");
    chk("R7 second buf", {31'd0, seq_buf}, 32'd0);
    ack();
    brd(1, 0, d); chk("R7 drain overlap", d, 32'hE1);
    fwr(0, 32'hE0);
    pulse_done();
    status(s); chk("R7 both full", s & 32'h3C, 32'h3C);
    reg_wr(3, 32'h14); reg_wr(3, 32'h04); reg_wr(4, 32'h1);
  endtask

  task automatic t_collide();
    logic [31:0] s;
    reg_wr(3, 32'h01);
    wait_seq("R9 setup");
    ack();
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1; xfer_done = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; xfer_done = 1'b0;
    chk("R9 set wins", {31'd0, irq}, 32'd1);
    reg_wr(4, 32'h1);
    chk("R9 cleared", {31'd0, irq}, 32'd0);
    reg_wr(3, 32'h04);
    status(s); chk("R10 final", s, 32'h0);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_claim_ignore();
    t_read();
    t_illegal();
    t_write();
    t_order();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule